// File: doc/BRIEF.md
# Memory Access Security Lock

This block sits between the chip's access requesters and its on-chip memories and decides, request by request, whether an access may reach them. Two requesters feed it: the host path, which carries traffic arriving over SPI, I2C or the one-wire link, and the debugger path. Each request is decoded into a target class: the OTP region, the EEPROM region, the RAM region, or the register page. The register page holds the lock register, the communication buffer register and other registers. Requests that are allowed are passed to a single shared memory port. Requests that are refused are answered locally with a deny flag and never reach that port.

Host access is controlled by an 8-bit lock register. Writing 0xAA to it locks the host path. Writing 0x00 unlocks it. Any other written value leaves the state as it was. Debugger access is controlled by a separate single bit, which the on-chip controller loads through a dedicated write strobe. The two locks act independently. In both cases the communication buffer register stays reachable. The lock register is always reachable from the host path, so that a locked part can be unlocked again.

One request is served at a time, under a four-state machine:
- ST_IDLE accepts a request. The host has priority when both requesters are valid in the same cycle.
- A forwarded request moves to ST_HOST_MEM or ST_DBG_MEM and stays there until the memory returns `mem_rsp_valid`.
- A denied request, or a request to the lock register, goes straight from ST_IDLE to ST_RESP.
- Each wait state moves to ST_RESP on the memory response.
- ST_RESP presents a one-cycle response to the owner and always returns to ST_IDLE.

A requester holds its request valid until it sees its response.

Top module: `sec_mem_gate`

## Requirements
- R1: After reset the host path and the debugger path are both unlocked, no memory request is pending, neither response is valid, and a host read of the lock register returns 0x00.
- R2: A write of 0xAA to the lock register locks the host path; while locked, a lock-register read returns 0xAA.
- R3: A write of 0x00 to the lock register unlocks the host path; while unlocked, a lock-register read returns 0x00.
- R4: A lock-register write of any value other than 0x00 or 0xAA leaves the lock state unchanged.
- R5: While the host path is locked, a host read of the OTP region (address bits [11:10] = 0), the EEPROM region (= 1), the RAM region (= 2), or any register-page address (= 3) other than the lock register or the communication buffer returns data 0 with the deny flag set, and raises no memory request.
- R6: While the host path is locked, a host write to those same targets is discarded: no memory request is raised, and the memory content is unchanged when it is later read back.
- R7: The communication buffer register (register page offset 0x001, address 0xC01) is forwarded to memory with no deny flag, whatever the state of either lock.
- R8: The lock register (register page offset 0x000, address 0xC00) is readable and writable from the host path at all times. It is served without a memory request.
- R9: The debug lock bit, loaded by `dbg_lock_we`/`dbg_lock_wdata`, blocks debugger access to every target except the communication buffer when it is 1. This includes the lock register. It permits debugger access when it is 0.
- R10: The host lock has no effect on the debugger path, and the debug lock bit has no effect on the host path.
- R11: Only one request is served at a time. When both requesters are valid in the same idle cycle, the host is served first and the debugger response follows after it.
- R12: A forwarded request drives `mem_req_valid` with the request's address, direction and write data, held stable until `mem_rsp_valid`. The requester's response follows in the next cycle with the memory data for reads, data 0 for writes, and no deny flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req_valid | input | 1 | Host request, held until host response |
| host_req_write | input | 1 | Host request is a write |
| host_req_addr | input | 12 | Host request address |
| host_req_wdata | input | 8 | Host write data |
| host_rsp_valid | output | 1 | One-cycle host response strobe |
| host_rsp_rdata | output | 8 | Host read data (0 when denied or write) |
| host_rsp_denied | output | 1 | Host request was refused |
| dbg_req_valid | input | 1 | Debugger request, held until debugger response |
| dbg_req_write | input | 1 | Debugger request is a write |
| dbg_req_addr | input | 12 | Debugger request address |
| dbg_req_wdata | input | 8 | Debugger write data |
| dbg_rsp_valid | output | 1 | One-cycle debugger response strobe |
| dbg_rsp_rdata | output | 8 | Debugger read data (0 when denied or write) |
| dbg_rsp_denied | output | 1 | Debugger request was refused |
| dbg_lock_we | input | 1 | Load strobe for the debug lock bit |
| dbg_lock_wdata | input | 1 | New debug lock bit value |
| mem_req_valid | output | 1 | Memory request, held until mem_rsp_valid |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 12 | Memory request address |
| mem_req_wdata | output | 8 | Memory write data |
| mem_rsp_valid | input | 1 | Memory completion strobe |
| mem_rsp_rdata | input | 8 | Memory read data |

## Verification
The bench goes after the lock codes themselves. It writes 0xAA, 0x00 and stray values such as 0x55 in both lock states. A decoder that treated any nonzero value as a lock, or that toggled the lock, would then report the wrong lock-register value or deny accesses it should allow. It targets the exemptions: the communication buffer and the lock register under each lock combination, and region edges such as 0x3FF, 0x400 and 0xBFF. A design with an off-by-one region decode, or one that denied the buffer, would return a deny flag or a spurious memory request where none belongs. Writes refused while locked are read back after unlocking to expose a gate that blocks the response but still leaks the write to memory. Simultaneous host and debugger requests, cross-checks between the two locks, and random traffic with varied memory latency expose a wrong priority and any coupling between the two lock states.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

    localparam int LOCK_W = 8;
    localparam logic [LOCK_W-1:0] CODE_LOCK = 8'hAA;
    localparam logic [LOCK_W-1:0] CODE_OPEN = 8'h00;

    localparam int NSRC    = 2;
    localparam int SRC_HST = 0;
    localparam int SRC_DBG = 1;

    typedef enum logic [2:0] {
        CL_OTP,
        CL_EEP,
        CL_RAM,
        CL_REG,
        CL_LOCKREG,
        CL_COMBUF
    } acc_class_t;

    typedef enum logic [1:0] {
        ACT_FORWARD,
        ACT_LOCAL,
        ACT_DENY
    } acc_action_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOST_MEM,
        ST_DBG_MEM,
        ST_RESP
    } gate_state_t;

endpackage

// File: rtl/sec_addr_decode.sv
module sec_addr_decode
    import sec_gate_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LOCK_OFS   = 0,
    parameter int COMBUF_OFS = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_class_t        cls
);

    localparam int OFS_W = ADDR_W - 2;
    localparam logic [OFS_W-1:0] LOCK_OFS_V   = OFS_W'(LOCK_OFS);
    localparam logic [OFS_W-1:0] COMBUF_OFS_V = OFS_W'(COMBUF_OFS);

    logic [1:0]       region;
    logic [OFS_W-1:0] offset;

    assign region = addr[ADDR_W-1 -: 2];
    assign offset = addr[OFS_W-1:0];

    always_comb begin
        unique case (region)
            2'd0:    cls = CL_OTP;
            2'd1:    cls = CL_EEP;
            2'd2:    cls = CL_RAM;
            default: begin
                if (offset == LOCK_OFS_V)
                    cls = CL_LOCKREG;
                else if (offset == COMBUF_OFS_V)
                    cls = CL_COMBUF;
                else
                    cls = CL_REG;
            end
        endcase
    end

endmodule

// File: rtl/sec_access_policy.sv
module sec_access_policy
    import sec_gate_pkg::*;
#(
    parameter bit FROM_DEBUG = 1'b0
) (
    input  acc_class_t  cls,
    input  logic        host_locked,
    input  logic        dbg_locked,
    output acc_action_t act
);

    logic gate;

    always_comb begin
        gate = FROM_DEBUG ? dbg_locked : host_locked;
        unique case (cls)
            CL_COMBUF:  act = ACT_FORWARD;
            CL_LOCKREG: act = (FROM_DEBUG && dbg_locked) ? ACT_DENY : ACT_LOCAL;
            default:    act = gate ? ACT_DENY : ACT_FORWARD;
        endcase
    end

endmodule

// File: rtl/sec_lock_regs.sv
module sec_lock_regs
    import sec_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_we,
    input  logic [LOCK_W-1:0] code_wdata,
    input  logic              dbg_we,
    input  logic              dbg_wdata,
    output logic              host_locked,
    output logic              dbg_locked,
    output logic [LOCK_W-1:0] code_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_locked <= 1'b0;
        end else if (code_we) begin
            if (code_wdata == CODE_LOCK)
                host_locked <= 1'b1;
            else if (code_wdata == CODE_OPEN)
                host_locked <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dbg_locked <= 1'b0;
        else if (dbg_we)
            dbg_locked <= dbg_wdata;
    end

    assign code_rdata = host_locked ? CODE_LOCK : CODE_OPEN;

    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (code_we && code_wdata == CODE_LOCK) |=> host_locked); // R2
    AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (code_we && code_wdata == CODE_OPEN) |=> !host_locked); // R3
    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(code_we && (code_wdata == CODE_LOCK || code_wdata == CODE_OPEN))) |=> $stable(host_locked)); // R4
    AST_DBG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_we |=> (dbg_locked == $past(dbg_wdata))); // R9

endmodule

// File: rtl/sec_mem_gate.sv
module sec_mem_gate
    import sec_gate_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int LOCK_OFS   = 0,
    parameter int COMBUF_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_valid,
    input  logic              host_req_write,
    input  logic [ADDR_W-1:0] host_req_addr,
    input  logic [DATA_W-1:0] host_req_wdata,
    output logic              host_rsp_valid,
    output logic [DATA_W-1:0] host_rsp_rdata,
    output logic              host_rsp_denied,
    input  logic              dbg_req_valid,
    input  logic              dbg_req_write,
    input  logic [ADDR_W-1:0] dbg_req_addr,
    input  logic [DATA_W-1:0] dbg_req_wdata,
    output logic              dbg_rsp_valid,
    output logic [DATA_W-1:0] dbg_rsp_rdata,
    output logic              dbg_rsp_denied,
    input  logic              dbg_lock_we,
    input  logic              dbg_lock_wdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);

    // per-source request view
    logic [NSRC-1:0]   src_valid;
    logic [NSRC-1:0]   src_write;
    logic [ADDR_W-1:0] src_addr  [NSRC];
    logic [DATA_W-1:0] src_wdata [NSRC];
    acc_class_t        src_cls   [NSRC];
    acc_action_t       src_act   [NSRC];

    logic host_locked;
    logic dbg_locked;
    logic [LOCK_W-1:0] lock_code;

    assign src_valid            = {dbg_req_valid, host_req_valid};
    assign src_write            = {dbg_req_write, host_req_write};
    assign src_addr[SRC_HST]    = host_req_addr;
    assign src_addr[SRC_DBG]    = dbg_req_addr;
    assign src_wdata[SRC_HST]   = host_req_wdata;
    assign src_wdata[SRC_DBG]   = dbg_req_wdata;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        sec_addr_decode #(
            .ADDR_W     (ADDR_W),
            .LOCK_OFS   (LOCK_OFS),
            .COMBUF_OFS (COMBUF_OFS)
        ) u_dec (
            .addr (src_addr[s]),
            .cls  (src_cls[s])
        );
        sec_access_policy #(
            .FROM_DEBUG (s == SRC_DBG)
        ) u_pol (
            .cls         (src_cls[s]),
            .host_locked (host_locked),
            .dbg_locked  (dbg_locked),
            .act         (src_act[s])
        );
    end

    // selection: host wins
    logic              pick_dbg;
    logic              accept;
    acc_action_t       sel_act;
    acc_class_t        sel_cls;
    logic              sel_write;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;

    assign pick_dbg  = !src_valid[SRC_HST];
    assign sel_act   = pick_dbg ? src_act[SRC_DBG]   : src_act[SRC_HST];
    assign sel_cls   = pick_dbg ? src_cls[SRC_DBG]   : src_cls[SRC_HST];
    assign sel_write = pick_dbg ? src_write[SRC_DBG] : src_write[SRC_HST];
    assign sel_addr  = pick_dbg ? src_addr[SRC_DBG]  : src_addr[SRC_HST];
    assign sel_wdata = pick_dbg ? src_wdata[SRC_DBG] : src_wdata[SRC_HST];

    gate_state_t state_q, state_d;

    assign accept = (state_q == ST_IDLE) && (|src_valid);

    logic code_we;
    assign code_we = accept && (sel_act == ACT_LOCAL) && sel_write;

    sec_lock_regs u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_we     (code_we),
        .code_wdata  (sel_wdata[LOCK_W-1:0]),
        .dbg_we      (dbg_lock_we),
        .dbg_wdata   (dbg_lock_wdata),
        .host_locked (host_locked),
        .dbg_locked  (dbg_locked),
        .code_rdata  (lock_code)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (sel_act == ACT_FORWARD)
                        state_d = pick_dbg ? ST_DBG_MEM : ST_HOST_MEM;
                    else
                        state_d = ST_RESP;
                end
            end
            ST_HOST_MEM, ST_DBG_MEM: begin
                if (mem_rsp_valid)
                    state_d = ST_RESP;
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // captured request and response data
    logic              owner_q;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    acc_class_t        cls_q;
    logic [DATA_W-1:0] rdata_q;
    logic              denied_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q  <= 1'b0;
            write_q  <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            cls_q    <= CL_OTP;
            rdata_q  <= '0;
            denied_q <= 1'b0;
        end else if (accept) begin
            owner_q  <= pick_dbg;
            write_q  <= sel_write;
            addr_q   <= sel_addr;
            wdata_q  <= sel_wdata;
            cls_q    <= sel_cls;
            denied_q <= (sel_act == ACT_DENY);
            rdata_q  <= (sel_act == ACT_LOCAL && !sel_write) ? DATA_W'(lock_code) : '0;
        end else if ((state_q == ST_HOST_MEM || state_q == ST_DBG_MEM) && mem_rsp_valid) begin
            rdata_q  <= write_q ? '0 : mem_rsp_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_req_valid   = (state_q == ST_HOST_MEM) || (state_q == ST_DBG_MEM);
        mem_req_write   = write_q;
        mem_req_addr    = addr_q;
        mem_req_wdata   = wdata_q;
        host_rsp_valid  = (state_q == ST_RESP) && !owner_q;
        dbg_rsp_valid   = (state_q == ST_RESP) && owner_q;
        host_rsp_rdata  = host_rsp_valid ? rdata_q : '0;
        dbg_rsp_rdata   = dbg_rsp_valid  ? rdata_q : '0;
        host_rsp_denied = host_rsp_valid && denied_q;
        dbg_rsp_denied  = dbg_rsp_valid  && denied_q;
    end

    AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOST_MEM) |-> (!host_locked || cls_q == CL_COMBUF)); // R5
    AST_DBG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_valid) && owner_q) |-> (!$past(dbg_locked) || cls_q == CL_COMBUF)); // R9
    AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rsp_valid && host_rsp_denied) |-> (host_rsp_rdata == '0)); // R5
    AST_COMBUF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESP && cls_q == CL_COMBUF) |-> !denied_q); // R7
    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && host_req_valid && dbg_req_valid) |=> !owner_q); // R11
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr))); // R12

endmodule

// File: tb/sec_mem_gate_tb.sv
module sec_mem_gate_tb_top;

    localparam int AW = 12;
    localparam int DW = 8;
    localparam logic [AW-1:0] A_LOCK   = 12'hC00;
    localparam logic [AW-1:0] A_COMBUF = 12'hC01;
    localparam int C_MEM = 0, C_REG = 3, C_LOCK = 4, C_BUF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          host_req_valid = 0, host_req_write = 0;
    logic [AW-1:0] host_req_addr = '0;
    logic [DW-1:0] host_req_wdata = '0;
    logic          host_rsp_valid, host_rsp_denied;
    logic [DW-1:0] host_rsp_rdata;
    logic          dbg_req_valid = 0, dbg_req_write = 0;
    logic [AW-1:0] dbg_req_addr = '0;
    logic [DW-1:0] dbg_req_wdata = '0;
    logic          dbg_rsp_valid, dbg_rsp_denied;
    logic [DW-1:0] dbg_rsp_rdata;
    logic          dbg_lock_we = 0, dbg_lock_wdata = 0;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 0;
    logic [DW-1:0] mem_rsp_rdata = '0;

    sec_mem_gate dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req_valid(host_req_valid), .host_req_write(host_req_write),
        .host_req_addr(host_req_addr), .host_req_wdata(host_req_wdata),
        .host_rsp_valid(host_rsp_valid), .host_rsp_rdata(host_rsp_rdata),
        .host_rsp_denied(host_rsp_denied),
        .dbg_req_valid(dbg_req_valid), .dbg_req_write(dbg_req_write),
        .dbg_req_addr(dbg_req_addr), .dbg_req_wdata(dbg_req_wdata),
        .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_rdata(dbg_rsp_rdata),
        .dbg_rsp_denied(dbg_rsp_denied),
        .dbg_lock_we(dbg_lock_we), .dbg_lock_wdata(dbg_lock_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    int fwd_count = 0;
    int lat_cfg = 0;
    int lat_cnt = 0;
    logic [DW-1:0] mem_model [0:4095];
    logic [DW-1:0] exp_mem   [0:4095];
    bit m_host = 0;
    bit m_dbg = 0;

    // memory responder with programmable latency
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (mem_req_valid) begin
            if (lat_cnt >= lat_cfg) begin
                lat_cnt = 0;
                fwd_count++;
                if (mem_req_write) begin
                    mem_model[mem_req_addr] = mem_req_wdata;
                    mem_rsp_rdata = 8'h5A;
                end else begin
                    mem_rsp_rdata = mem_model[mem_req_addr];
                end
                mem_rsp_valid = 1'b1;
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_class(logic [AW-1:0] a);
        if (a[11:10] != 2'd3) return C_MEM;
        if (a == A_LOCK) return C_LOCK;
        if (a == A_COMBUF) return C_BUF;
        return C_REG;
    endfunction

    // 0 forward, 1 local, 2 deny
    function automatic int exp_action(bit dbg, int cls);
        if (cls == C_BUF) return 0;
        if (cls == C_LOCK) return (dbg && m_dbg) ? 2 : 1;
        return (dbg ? m_dbg : m_host) ? 2 : 0;
    endfunction

    task automatic drive(bit dbg, bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
        if (dbg) begin
            dbg_req_valid = 1; dbg_req_write = wr; dbg_req_addr = a; dbg_req_wdata = d;
        end else begin
            host_req_valid = 1; host_req_write = wr; host_req_addr = a; host_req_wdata = d;
        end
    endtask

    task automatic await(bit dbg, output logic [DW-1:0] rd, output bit den, output bit ok);
        ok = 0; rd = '0; den = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dbg ? dbg_rsp_valid : host_rsp_valid) begin
                rd  = dbg ? dbg_rsp_rdata : host_rsp_rdata;
                den = dbg ? dbg_rsp_denied : host_rsp_denied;
                if (dbg) dbg_req_valid = 0; else host_req_valid = 0;
                ok = 1;
                return;
            end
        end
        check(0, "TIMEOUT", "response", 0, 1);
        if (dbg) dbg_req_valid = 0; else host_req_valid = 0;
    endtask

    task automatic xact(bit dbg, bit wr, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        int cls = exp_class(a);
        int act = exp_action(dbg, cls);
        bit exp_den = (act == 2);
        logic [DW-1:0] exp_rd;
        logic [DW-1:0] rd;
        bit den, ok;
        int f0;
        if (wr || act == 2) exp_rd = '0;
        else if (act == 1) exp_rd = m_host ? 8'hAA : 8'h00;
        else exp_rd = exp_mem[a];
        @(negedge clk);
        f0 = fwd_count;
        drive(dbg, wr, a, d);
        await(dbg, rd, den, ok);
        if (!ok) return;
        check(den == exp_den, tag, "denied", int'(den), int'(exp_den));
        check(rd == exp_rd, tag, "rdata", int'(rd), int'(exp_rd));
        check((fwd_count - f0) == ((act == 0) ? 1 : 0), tag, "mem requests",
              fwd_count - f0, (act == 0) ? 1 : 0);
        if (wr && act == 0) exp_mem[a] = d;
        if (wr && act == 1) begin
            if (d == 8'hAA) m_host = 1;
            else if (d == 8'h00) m_host = 0;
        end
    endtask

    task automatic set_dbg_lock(bit v);
        @(negedge clk);
        dbg_lock_we = 1; dbg_lock_wdata = v;
        @(negedge clk);
        dbg_lock_we = 0;
        m_dbg = v;
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int r = $urandom % 10;
        case (r)
            0: return A_LOCK;
            1: return A_COMBUF;
            2: return 12'hC02 + 12'($urandom % 64);
            3: return 12'h3FF;
            4: return 12'h400;
            5: return 12'hBFF;
            default: return 12'($urandom % 3072);
        endcase
    endfunction

    function automatic string rand_tag(bit dbg, bit wr, logic [AW-1:0] a);
        int cls = exp_class(a);
        int act = exp_action(dbg, cls);
        if (cls == C_BUF) return "R7";
        if (cls == C_LOCK) return dbg ? "R9" : "R8";
        if (act == 2) return dbg ? "R9" : (wr ? "R6" : "R5");
        if (dbg) return "R10";
        return "R12";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL WATCHDOG run did not complete actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        bit den, ok;
        int f0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) begin
            mem_model[i] = 8'((i * 7 + 3) ^ (i >> 4));
            exp_mem[i]   = mem_model[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(mem_req_valid == 0, "R1", "mem_req_valid", int'(mem_req_valid), 0);
        check(host_rsp_valid == 0 && dbg_rsp_valid == 0, "R1", "rsp_valid",
              int'(host_rsp_valid | dbg_rsp_valid), 0);
        xact(0, 0, A_LOCK, 0, "R1");
        xact(1, 0, 12'h010, 0, "R1");

        // R12 forwarded traffic, with latency
        lat_cfg = 2;
        xact(0, 0, 12'h000, 0, "R12");
        xact(0, 1, 12'h805, 8'h3C, "R12");
        xact(0, 0, 12'h805, 0, "R12");
        lat_cfg = 0;

        // R2 lock, R8 lock register while locked
        xact(0, 1, A_LOCK, 8'hAA, "R2");
        xact(0, 0, A_LOCK, 0, "R2");
        xact(0, 0, 12'h900, 0, "R5");
        xact(0, 0, 12'h3FF, 0, "R5");
        xact(0, 0, 12'hC05, 0, "R5");
        xact(0, 1, 12'h400, 8'hE7, "R6");

        // R4 stray codes
        xact(0, 1, A_LOCK, 8'h55, "R4");
        xact(0, 0, A_LOCK, 0, "R4");
        xact(0, 1, A_LOCK, 8'h01, "R4");
        xact(0, 0, 12'h100, 0, "R4");

        // R7 buffer while locked, R10 debugger unaffected by host lock
        xact(0, 1, A_COMBUF, 8'h91, "R7");
        xact(0, 0, A_COMBUF, 0, "R7");
        xact(1, 0, 12'h400, 0, "R10");

        // R3 unlock, R6 discarded write read back
        xact(0, 1, A_LOCK, 8'h00, "R3");
        xact(0, 0, A_LOCK, 0, "R3");
        xact(0, 0, 12'h400, 0, "R6");
        xact(0, 1, A_LOCK, 8'h77, "R4");
        xact(0, 0, 12'h401, 0, "R4");

        // R9 debug lock, R10 host unaffected
        set_dbg_lock(1);
        xact(1, 0, 12'h810, 0, "R9");
        xact(1, 1, 12'h011, 8'h22, "R9");
        xact(1, 1, A_LOCK, 8'hAA, "R9");
        xact(0, 0, A_LOCK, 0, "R9");
        xact(1, 0, A_COMBUF, 0, "R7");
        xact(0, 0, 12'h810, 0, "R10");
        set_dbg_lock(0);
        xact(1, 0, 12'h011, 0, "R9");

        // R11 simultaneous requests
        @(negedge clk);
        f0 = fwd_count;
        drive(0, 0, 12'h820, 0);
        drive(1, 0, 12'h030, 0);
        await(0, rd, den, ok);
        check(ok && dbg_rsp_valid == 0, "R11", "debugger answered with host", int'(dbg_rsp_valid), 0);
        check(rd == exp_mem[12'h820], "R11", "host rdata", int'(rd), int'(exp_mem[12'h820]));
        await(1, rd, den, ok);
        check(ok && rd == exp_mem[12'h030], "R11", "debugger rdata", int'(rd), int'(exp_mem[12'h030]));
        check(fwd_count - f0 == 2, "R11", "mem requests", fwd_count - f0, 2);

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 10;
            lat_cfg = $urandom % 3;
            if (op == 0) begin
                set_dbg_lock(1'($urandom % 2));
            end else if (op == 1) begin
                int c = $urandom % 3;
                logic [DW-1:0] code = (c == 0) ? 8'h00 : (c == 1) ? 8'hAA : 8'($urandom);
                string t = (code == 8'hAA) ? "R2" : (code == 8'h00) ? "R3" : "R4";
                xact(0, 1, A_LOCK, code, t);
            end else begin
                bit dbg = ($urandom % 3) == 0;
                bit wr  = ($urandom % 2) == 0;
                logic [AW-1:0] a = pick_addr();
                logic [DW-1:0] d = 8'($urandom);
                if (wr && a == A_LOCK) d = 8'h5C;
                xact(dbg, wr, a, d, rand_tag(dbg, wr, a));
            end
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule